// File: doc/BRIEF.md
# Display Register Front End with Hidden Colour-Mode Register

This block is the byte-wide, memory-mapped register front end of a display controller. A 32-byte window is decoded into three index/data register pairs (sequencer, CRT controller and graphics controller) and a pixel-mask port. Software first writes a register number to an index offset. It then reads or writes the paired data offset, and that access reaches the register the latched index selects. Reads return data one cycle after the request, together with a valid strobe.

The pixel-mask port also guards a hidden colour-mode register. A run of four or more consecutive reads of the mask port arms the port. The next write to the port then lands in the hidden register and the mask is left untouched. The block exports the mask and the hidden register value. From the low five bits of sequencer register 7 it decodes the pixel depth in bits per pixel, and it flags a depth code it does not recognise.

Top module: `disp_regfront`

## Requirements
- R1: A read request returns its data on `rdata_o` with `rvalid_o` high in the cycle after the request. Offsets that map to nothing read as 0x00 and ignore writes.
- R2: The index offsets are 0x04 (sequencer), 0x14 (CRT) and 0x0E (graphics). The data offsets are 0x05, 0x15 and 0x0F. A data access reaches the register selected by the last value written to the pair's own index offset. Each index offset reads back its full 8-bit latched value.
- R3: The sequencer implements 8 registers, the CRT controller 32 and the graphics controller 16. A data access whose index is at or above that count reads 0x00, and a write to it changes nothing.
- R4: Offset 0x06 holds the pixel mask. It resets to 0xFF, and a read or an unarmed write of that offset reads or replaces it.
- R5: After four or more consecutive reads of offset 0x06, the next write to 0x06 updates `hidden_o` and leaves the mask unchanged. That write disarms the port.
- R6: Any access to another offset, and any write to 0x06, restarts the read count. Cycles without a request do not restart it.
- R7: `bpp_o` is decoded from bits [4:0] of sequencer register 7: 0x11 gives 8, 0x17 gives 16, 0x15 gives 24 and 0x19 gives 32. Bits [7:5] have no effect on the decode.
- R8: Any other code drives `bpp_o` to 0 and `depth_bad_o` to 1. A valid code clears `depth_bad_o`.
- R9: After reset, all indexed registers and `hidden_o` are 0x00 (0x00 means palette mode), the mask is 0xFF, `rvalid_o` is 0 and `depth_bad_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request for this cycle |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 5 | Byte offset within the window |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid when rvalid_o is high |
| rvalid_o | output | 1 | Read data strobe, one cycle after a read |
| mask_o | output | 8 | Pixel mask |
| hidden_o | output | 8 | Hidden colour-mode register |
| depth_code_o | output | 5 | Low five bits of sequencer register 7 |
| bpp_o | output | 6 | Decoded bits per pixel, 0 when invalid |
| depth_bad_o | output | 1 | Depth code not recognised |

## Verification
The write that consumes an armed unlock does two things in the same cycle: it steers the data to the hidden register and it restarts the read count. The bench provokes this with a write placed right after the fourth mask read, and with a fifth read before the write. It then writes 0x06 a second time. It judges the result by seeing `hidden_o` take the first value while `mask_o` holds, and the second write then land in the mask. Runs broken by an access to a neighbouring offset, and runs separated by idle cycles, show whether the count restarts only on the accesses R6 lists.

// File: rtl/disp_regfront_pkg.sv
package disp_regfront_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFS_SEQ_IDX = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_SEQ_DAT = 5'h05;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_GFX_IDX = 5'h0E;
  localparam logic [ADDR_W-1:0] OFS_GFX_DAT = 5'h0F;
  localparam logic [ADDR_W-1:0] OFS_CRT_IDX = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_CRT_DAT = 5'h15;

  localparam int unsigned DEPTH_REG = 7;
  localparam int unsigned UNLOCK_RD = 4;

  typedef enum logic [4:0] {
    DEPTH_8  = 5'h11,
    DEPTH_16 = 5'h17,
    DEPTH_24 = 5'h15,
    DEPTH_32 = 5'h19
  } depth_code_e;
endpackage

// File: rtl/regfront_pair.sv
module regfront_pair #(
  parameter int unsigned NREG = 8,
  parameter int unsigned DW   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idx_we_i,
  input  logic             dat_we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    idx_o,
  output logic [DW-1:0]    rdata_o,
  output logic [NREG*DW-1:0] regs_o
);
  localparam int unsigned IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DW-1:0] idx_q;
  logic [DW-1:0] regs_q [NREG];
  logic          hit;

  assign hit = (idx_q < DW'(NREG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (idx_we_i) idx_q <= wdata_i;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (dat_we_i && hit && (idx_q[IW-1:0] == IW'(g))) regs_q[g] <= wdata_i;
    end
    assign regs_o[g*DW +: DW] = regs_q[g];
  end

  assign idx_o   = idx_q;
  assign rdata_o = hit ? regs_q[idx_q[IW-1:0]] : '0;
endmodule

// File: rtl/regfront_maskport.sv
module regfront_maskport #(
  parameter int unsigned DW        = 8,
  parameter int unsigned UNLOCK_RD = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] hidden_o
);
  localparam int unsigned CW = $clog2(UNLOCK_RD + 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] mask_q, hidden_q;
  logic          armed;

  assign armed = (cnt_q == CW'(UNLOCK_RD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      mask_q   <= '1;
      hidden_q <= '0;
    end else if (acc_i) begin
      if (sel_i && !we_i) begin
        if (!armed) cnt_q <= cnt_q + CW'(1);
      end else begin
        cnt_q <= '0;
      end
      if (sel_i && we_i) begin
        if (armed) hidden_q <= wdata_i;
        else       mask_q   <= wdata_i;
      end
    end
  end

  assign mask_o   = mask_q;
  assign hidden_o = hidden_q;
endmodule

// File: rtl/regfront_depth.sv
module regfront_depth
  import disp_regfront_pkg::*;
(
  input  logic [4:0] code_i,
  output logic [5:0] bpp_o,
  output logic       bad_o
);
  always_comb begin
    bad_o = 1'b0;
    unique case (code_i)
      DEPTH_8:  bpp_o = 6'd8;
      DEPTH_16: bpp_o = 6'd16;
      DEPTH_24: bpp_o = 6'd24;
      DEPTH_32: bpp_o = 6'd32;
      default: begin
        bpp_o = 6'd0;
        bad_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/disp_regfront.sv
module disp_regfront
  import disp_regfront_pkg::*;
#(
  parameter int unsigned NSEQ = 8,
  parameter int unsigned NCRT = 32,
  parameter int unsigned NGFX = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] hidden_o,
  output logic [4:0]        depth_code_o,
  output logic [5:0]        bpp_o,
  output logic              depth_bad_o
);
  localparam int unsigned NPAIR = 3;
  localparam int unsigned NMAX  = (NSEQ > NCRT) ? ((NSEQ > NGFX) ? NSEQ : NGFX)
                                                : ((NCRT > NGFX) ? NCRT : NGFX);
  localparam int unsigned NREG_A [NPAIR] = '{NSEQ, NCRT, NGFX};
  localparam logic [ADDR_W-1:0] IDX_OFS [NPAIR] = '{OFS_SEQ_IDX, OFS_CRT_IDX, OFS_GFX_IDX};
  localparam logic [ADDR_W-1:0] DAT_OFS [NPAIR] = '{OFS_SEQ_DAT, OFS_CRT_DAT, OFS_GFX_DAT};

  logic [DATA_W-1:0] p_idx [NPAIR];
  logic [DATA_W-1:0] p_dat [NPAIR];
  logic [NSEQ*DATA_W-1:0] seq_regs;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              rvalid_q;
  logic              wr;

  assign wr = req_i && we_i;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic [NREG_A[p]*DATA_W-1:0] regs;
    regfront_pair #(.NREG(NREG_A[p]), .DW(DATA_W)) u_pair (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .idx_we_i (wr && (addr_i == IDX_OFS[p])),
      .dat_we_i (wr && (addr_i == DAT_OFS[p])),
      .wdata_i  (wdata_i),
      .idx_o    (p_idx[p]),
      .rdata_o  (p_dat[p]),
      .regs_o   (regs)
    );
    if (p == 0) begin : g_seq
      assign seq_regs = regs;
    end
  end

  regfront_maskport #(.DW(DATA_W), .UNLOCK_RD(UNLOCK_RD)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (req_i),
    .sel_i    (addr_i == OFS_MASK),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .mask_o   (mask_o),
    .hidden_o (hidden_o)
  );

  assign depth_code_o = seq_regs[DEPTH_REG*DATA_W +: 5];

  regfront_depth u_depth (
    .code_i (depth_code_o),
    .bpp_o  (bpp_o),
    .bad_o  (depth_bad_o)
  );

  always_comb begin
    rd_mux = '0;
    if (addr_i == OFS_MASK) rd_mux = mask_o;
    for (int p = 0; p < NPAIR; p++) begin
      if (addr_i == IDX_OFS[p]) rd_mux = p_idx[p];
      if (addr_i == DAT_OFS[p]) rd_mux = p_dat[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= req_i && !we_i;
      if (req_i && !we_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  initial begin
    if (NSEQ <= DEPTH_REG) $error("NSEQ must exceed the depth register number");
    if (NMAX > 256) $error("register count exceeds index range");
  end
endmodule

// File: rtl/disp_regfront_chk.sv
module disp_regfront_chk
  import disp_regfront_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rvalid_o,
  input logic [DATA_W-1:0] mask_o,
  input logic [DATA_W-1:0] hidden_o,
  input logic [4:0]        depth_code_o,
  input logic [5:0]        bpp_o,
  input logic              depth_bad_o
);
  logic [2:0] rd_run;
  logic       mwr, armed;

  assign mwr   = req_i && we_i && (addr_i == OFS_MASK);
  assign armed = (rd_run >= 3'(UNLOCK_RD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_run <= '0;
    else if (req_i) begin
      if (!we_i && addr_i == OFS_MASK) rd_run <= armed ? rd_run : rd_run + 3'd1;
      else                             rd_run <= '0;
    end
  end

  p_read_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i));

  p_armed_keeps_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mwr && armed) |=> $stable(mask_o));

  p_unarmed_keeps_hidden_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mwr && armed) |=> $stable(hidden_o));

  p_depth_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == OFS_SEQ_DAT) |=> $stable(depth_code_o));

  p_bad_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_bad_o |-> (bpp_o == 6'd0));

  p_good_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !depth_bad_o |-> (bpp_o == 6'd8 || bpp_o == 6'd16 || bpp_o == 6'd24 || bpp_o == 6'd32));
endmodule

bind disp_regfront disp_regfront_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .rvalid_o     (rvalid_o),
  .mask_o       (mask_o),
  .hidden_o     (hidden_o),
  .depth_code_o (depth_code_o),
  .bpp_o        (bpp_o),
  .depth_bad_o  (depth_bad_o)
);

// File: tb/sim_disp_regfront.sv
`timescale 1ns/1ps
module sim_disp_regfront;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, mask, hidden;
  logic       rvalid, dbad;
  logic [4:0] dcode;
  logic [5:0] bpp;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  disp_regfront u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .mask_o(mask),
    .hidden_o(hidden), .depth_code_o(dcode), .bpp_o(bpp), .depth_bad_o(dbad)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    acc(1'b1, a, d);
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    acc(1'b0, a, 8'h00);
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) chk("R1 unexpected rvalid", 1, 0);
      else begin
        string t;
        logic [7:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, rdata, e);
      end
    end
  end

  task automatic set_depth(input logic [7:0] v, input int eb, input int ebad);
    wr(5'h04, 8'd7);
    wr(5'h05, v);
    chk("R7 bpp", bpp, eb);
    chk("R8 bad flag", dbad, ebad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 mask reset", mask, 8'hFF);
    chk("R9 hidden reset", hidden, 8'h00);
    chk("R9 rvalid reset", rvalid, 0);
    chk("R9 bad reset", dbad, 1);
    rd(5'h05, 8'h00, "R9 seq reg0 reset");

    // R7 / R8 depth decode
    set_depth(8'h11, 8, 0);
    set_depth(8'hF1, 8, 0);
    set_depth(8'h17, 16, 0);
    set_depth(8'h15, 24, 0);
    set_depth(8'hB9, 32, 0);
    chk("R7 code low bits", dcode, 5'h19);
    set_depth(8'h05, 0, 1);
    rd(5'h05, 8'h05, "R2 seq data readback");
    rd(5'h04, 8'h07, "R2 seq index readback");

    // R2 / R3 CRT and graphics pairs
    wr(5'h14, 8'h13); wr(5'h15, 8'hAB);
    wr(5'h14, 8'h07); wr(5'h15, 8'h77);
    chk("R2 crt write leaves seq depth", bpp, 0);
    wr(5'h14, 8'h13);
    rd(5'h15, 8'hAB, "R2 crt data readback");
    wr(5'h14, 8'h20); wr(5'h15, 8'h55);
    rd(5'h15, 8'h00, "R3 crt beyond count");
    rd(5'h14, 8'h20, "R2 crt index readback");
    wr(5'h0E, 8'h05); wr(5'h0F, 8'h40);
    rd(5'h0F, 8'h40, "R2 gfx data readback");
    wr(5'h0E, 8'h10); wr(5'h0F, 8'h99);
    rd(5'h0F, 8'h00, "R3 gfx beyond count");
    wr(5'h0E, 8'h00);
    rd(5'h0F, 8'h00, "R3 gfx reg0 untouched");
    wr(5'h04, 8'h08); wr(5'h05, 8'h66);
    rd(5'h05, 8'h00, "R3 seq beyond count");
    wr(5'h04, 8'h00);
    rd(5'h05, 8'h00, "R3 seq reg0 untouched");

    // R1 unmapped
    wr(5'h1F, 8'hEE);
    rd(5'h1F, 8'h00, "R1 unmapped read");
    rd(5'h00, 8'h00, "R1 unmapped read 0");

    // R4 mask
    wr(5'h06, 8'h0F);
    chk("R4 mask write", mask, 8'h0F);
    rd(5'h06, 8'h0F, "R4 mask read");

    // R5 unlock: 4 reads then write (one read already counted above is consumed by clear below)
    wr(5'h00, 8'h00);
    for (int i = 0; i < 4; i++) rd(5'h06, 8'h0F, "R5 arming read");
    wr(5'h06, 8'hC1);
    chk("R5 hidden written", hidden, 8'hC1);
    chk("R5 mask kept", mask, 8'h0F);
    wr(5'h06, 8'h33);
    chk("R5 disarmed after write", mask, 8'h33);
    chk("R5 hidden kept", hidden, 8'hC1);

    // R6 three reads is not enough
    for (int i = 0; i < 3; i++) rd(5'h06, 8'h33, "R6 short run read");
    wr(5'h06, 8'h44);
    chk("R6 short run to mask", mask, 8'h44);
    chk("R6 short run hidden", hidden, 8'hC1);

    // R6 interrupted run
    for (int i = 0; i < 3; i++) rd(5'h06, 8'h44, "R6 run read");
    rd(5'h05, 8'h00, "R6 interrupting read");
    rd(5'h06, 8'h44, "R6 run read after break");
    wr(5'h06, 8'h55);
    chk("R6 interrupted to mask", mask, 8'h55);
    chk("R6 interrupted hidden", hidden, 8'hC1);

    // R5 five reads, then write
    for (int i = 0; i < 5; i++) rd(5'h06, 8'h55, "R5 long run read");
    wr(5'h06, 8'hC5);
    chk("R5 long run hidden", hidden, 8'hC5);
    chk("R5 long run mask", mask, 8'h55);

    // R6 idle cycles do not break the run
    for (int i = 0; i < 4; i++) begin
      rd(5'h06, 8'h55, "R6 idle run read");
      repeat (2) @(negedge clk);
    end
    wr(5'h06, 8'h00);
    chk("R6 idle run hidden palette", hidden, 8'h00);
    chk("R6 idle run mask", mask, 8'h55);

    repeat (3) @(negedge clk);
    chk("R1 all reads returned", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule